// File: doc/BRIEF.md
# Serial Timeslot Byte Monitor

This block taps one 64 kbps timeslot out of a T1 or E1 serial bit stream and holds its latest 8-bit value in a register that the rest of the chip can read. Two identical paths sit side by side, one watching the transmit stream and one watching the receive stream. Each path has its own 5-bit slot select, its own line-mode input and its own captured byte, and the two paths never interact.

Each path runs in the system clock domain. A bit strobe marks the cycle that carries a valid serial bit, and a frame-start input, asserted together with the strobe, marks bit 0 of a frame. The select value is the channel number minus one: 0 to 23 in T1 mode and 0 to 31 in E1 mode. After the last bit of the chosen slot arrives, the byte register updates as a whole and a one-cycle done pulse is raised. The select and mode are sampled only on a frame-start bit, so a change never mixes two slots inside one byte.

Top module: `tsmon_top`

## Requirements
- R1: While reset is high and in the first cycle after it, both captured bytes read 0x00 and both done outputs are low.
- R2: In E1 mode (mode input 1), slot k is carried by frame bits 8k to 8k+7, where the frame-start bit is bit 0. The first bit of the slot becomes bit 7 of the byte. Bytes and done change in the clock cycle that follows the strobe carrying the slot's eighth bit.
- R3: In T1 mode (mode input 0), frame bit 0 is a framing bit that belongs to no slot. Slot k is carried by frame bits 1+8k to 8+8k of the 193-bit frame. Bits are ordered MSB first, as in R2.
- R4: The captured byte changes only in a cycle where done is high. Otherwise it holds its value.
- R5: Done is high for exactly one cycle per capture, and there is exactly one capture per frame for a valid select.
- R6: In T1 mode, a select of 24 to 31 gives no capture and the byte keeps its last value. In E1 mode, select 31 (channel 32) is captured.
- R7: The select and the mode are sampled on the frame-start bit. A change made during a frame is used from the next frame start.
- R8: The transmit and receive paths use separate selects, modes and streams. They capture in the same frames without affecting each other.
- R9: Bits strobed after reset but before the first frame-start pulse are not captured.
- R10: Cycles without a bit strobe do not advance the bit position, and the data input is ignored in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sel | input | 5 | Transmit slot select (channel minus one) |
| tx_e1 | input | 1 | Transmit line mode: 1 = E1, 0 = T1 |
| tx_bit_stb | input | 1 | Transmit serial bit valid this cycle |
| tx_data | input | 1 | Transmit serial data |
| tx_frame_start | input | 1 | Transmit frame bit 0 marker, valid with the strobe |
| tx_mon_byte | output | 8 | Last captured transmit slot byte |
| tx_mon_done | output | 1 | One-cycle pulse when the transmit byte updates |
| rx_sel | input | 5 | Receive slot select (channel minus one) |
| rx_e1 | input | 1 | Receive line mode: 1 = E1, 0 = T1 |
| rx_bit_stb | input | 1 | Receive serial bit valid this cycle |
| rx_data | input | 1 | Receive serial data |
| rx_frame_start | input | 1 | Receive frame bit 0 marker, valid with the strobe |
| rx_mon_byte | output | 8 | Last captured receive slot byte |
| rx_mon_done | output | 1 | One-cycle pulse when the receive byte updates |

## Verification
The captured byte and the done pulse are due one clock after the strobe that carries the slot's last bit. A select change is due at the next frame-start bit. The bench changes inputs on the falling edge and samples 1 ns after each rising edge. For each path it records the bit index of the strobe just before each done pulse, so every check compares the exact timing bit (8k+7 for E1, 8k+8 for T1), the done count and the byte. Gap cycles between strobes carry toggling data, so any bit taken outside a strobe would change both the byte and the recorded index.

// File: rtl/tsmon_pkg.sv
package tsmon_pkg;
  typedef enum logic {
    MODE_T1 = 1'b0,
    MODE_E1 = 1'b1
  } line_mode_e;
endpackage

// File: rtl/tsmon_bit_position.sv
module tsmon_bit_position #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             frame_start,
  output logic [POS_W-1:0] cur_pos,
  output logic             pos_ok
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q;
  logic             seen_q;

  always_comb begin
    if (frame_start)           cur_pos = '0;
    else if (pos_q == POS_MAX) cur_pos = POS_MAX;
    else                       cur_pos = pos_q + 1'b1;
  end

  assign pos_ok = seen_q | frame_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= POS_MAX;
      seen_q <= 1'b0;
    end else if (bit_stb) begin
      pos_q <= cur_pos;
      if (frame_start) seen_q <= 1'b1;
    end
  end

  // R10: position only moves on a strobed bit
  a_r10_pos_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(pos_q));
endmodule

// File: rtl/tsmon_slot_select.sv
module tsmon_slot_select
  import tsmon_pkg::*;
#(
  parameter int SEL_W    = 5,
  parameter int POS_W    = 9,
  parameter int BYTE_W   = 8,
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             frame_start,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             e1_in,
  input  logic [POS_W-1:0] cur_pos,
  input  logic             pos_ok,
  output logic             in_slot,
  output logic             last_bit
);
  localparam int EXT_W = POS_W + 1;

  logic [SEL_W-1:0] act_sel_q, eff_sel;
  line_mode_e       act_mode_q, eff_mode;
  logic             latch_now;
  logic             sel_ok;
  logic [EXT_W-1:0] base, pos_x, off;

  assign latch_now = bit_stb & frame_start;

  always_comb begin
    eff_sel  = latch_now ? sel_in : act_sel_q;
    eff_mode = latch_now ? (e1_in ? MODE_E1 : MODE_T1) : act_mode_q;
    base     = EXT_W'(eff_sel) * EXT_W'(BYTE_W)
             + ((eff_mode == MODE_T1) ? EXT_W'(1) : EXT_W'(0));
    pos_x    = EXT_W'(cur_pos);
    off      = pos_x - base;
    sel_ok   = (eff_mode == MODE_E1) ? (int'(eff_sel) < E1_SLOTS)
                                     : (int'(eff_sel) < T1_SLOTS);
    in_slot  = bit_stb & pos_ok & sel_ok & (pos_x >= base)
             & (off < EXT_W'(BYTE_W));
    last_bit = in_slot & (off == EXT_W'(BYTE_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel_q  <= '0;
      act_mode_q <= MODE_T1;
    end else if (latch_now) begin
      act_sel_q  <= sel_in;
      act_mode_q <= eff_mode;
    end
  end

  // R7: selection only taken on a frame-start bit
  a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
    !(bit_stb && frame_start) |=> $stable(act_sel_q));
endmodule

// File: rtl/tsmon_byte_capture.sv
module tsmon_byte_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_slot,
  input  logic              last_bit,
  input  logic              data,
  output logic [BYTE_W-1:0] mon_byte,
  output logic              done
);
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] next_byte;

  assign next_byte = {shift_q[BYTE_W-2:0], data};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      mon_byte <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_bit;
      if (in_slot) shift_q <= next_byte;
      if (last_bit) mon_byte <= next_byte;
    end
  end

  // R4: byte only changes together with done
  a_r4_byte_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(mon_byte));
  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/tsmon_path.sv
module tsmon_path #(
  parameter int SEL_W    = 5,
  parameter int POS_W    = 9,
  parameter int BYTE_W   = 8,
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              e1,
  input  logic              bit_stb,
  input  logic              data,
  input  logic              frame_start,
  output logic [BYTE_W-1:0] mon_byte,
  output logic              done
);
  logic [POS_W-1:0] cur_pos;
  logic             pos_ok;
  logic             in_slot;
  logic             last_bit;

  tsmon_bit_position #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_start(frame_start),
    .cur_pos(cur_pos), .pos_ok(pos_ok)
  );

  tsmon_slot_select #(
    .SEL_W(SEL_W), .POS_W(POS_W), .BYTE_W(BYTE_W),
    .T1_SLOTS(T1_SLOTS), .E1_SLOTS(E1_SLOTS)
  ) u_sel (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_start(frame_start),
    .sel_in(sel), .e1_in(e1), .cur_pos(cur_pos), .pos_ok(pos_ok),
    .in_slot(in_slot), .last_bit(last_bit)
  );

  tsmon_byte_capture #(.BYTE_W(BYTE_W)) u_cap (
    .clk(clk), .rst(rst), .in_slot(in_slot), .last_bit(last_bit),
    .data(data), .mon_byte(mon_byte), .done(done)
  );

  // R2: a capture always follows a strobed bit
  a_r2_done_after_stb: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bit_stb));
endmodule

// File: rtl/tsmon_top.sv
module tsmon_top #(
  parameter int SEL_W    = 5,
  parameter int POS_W    = 9,
  parameter int BYTE_W   = 8,
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  tx_sel,
  input  logic              tx_e1,
  input  logic              tx_bit_stb,
  input  logic              tx_data,
  input  logic              tx_frame_start,
  output logic [BYTE_W-1:0] tx_mon_byte,
  output logic              tx_mon_done,
  input  logic [SEL_W-1:0]  rx_sel,
  input  logic              rx_e1,
  input  logic              rx_bit_stb,
  input  logic              rx_data,
  input  logic              rx_frame_start,
  output logic [BYTE_W-1:0] rx_mon_byte,
  output logic              rx_mon_done
);
  localparam int NUM_PATHS = 2;

  logic [SEL_W-1:0]  sel_a  [NUM_PATHS];
  logic              e1_a   [NUM_PATHS];
  logic              stb_a  [NUM_PATHS];
  logic              dat_a  [NUM_PATHS];
  logic              fs_a   [NUM_PATHS];
  logic [BYTE_W-1:0] mon_a  [NUM_PATHS];
  logic              done_a [NUM_PATHS];

  assign sel_a[0] = tx_sel;     assign sel_a[1] = rx_sel;
  assign e1_a[0]  = tx_e1;      assign e1_a[1]  = rx_e1;
  assign stb_a[0] = tx_bit_stb; assign stb_a[1] = rx_bit_stb;
  assign dat_a[0] = tx_data;    assign dat_a[1] = rx_data;
  assign fs_a[0]  = tx_frame_start;
  assign fs_a[1]  = rx_frame_start;

  // R8: one independent path per direction
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    tsmon_path #(
      .SEL_W(SEL_W), .POS_W(POS_W), .BYTE_W(BYTE_W),
      .T1_SLOTS(T1_SLOTS), .E1_SLOTS(E1_SLOTS)
    ) u_path (
      .clk(clk), .rst(rst), .sel(sel_a[p]), .e1(e1_a[p]),
      .bit_stb(stb_a[p]), .data(dat_a[p]), .frame_start(fs_a[p]),
      .mon_byte(mon_a[p]), .done(done_a[p])
    );
  end

  assign tx_mon_byte = mon_a[0];
  assign tx_mon_done = done_a[0];
  assign rx_mon_byte = mon_a[1];
  assign rx_mon_done = done_a[1];
endmodule

// File: tb/tsmon_top_bench.sv
`timescale 1ns/1ps
module tsmon_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] tx_sel = '0, rx_sel = '0;
  logic       tx_e1 = 1'b0, rx_e1 = 1'b0;
  logic       tx_bit_stb = 1'b0, rx_bit_stb = 1'b0;
  logic       tx_data = 1'b0, rx_data = 1'b0;
  logic       tx_frame_start = 1'b0, rx_frame_start = 1'b0;
  logic [7:0] tx_mon_byte, rx_mon_byte;
  logic       tx_mon_done, rx_mon_done;

  int checks = 0;
  int failures = 0;
  int tx_idx = 0, rx_idx = 0;
  int tx_dcnt = 0, rx_dcnt = 0;
  int tx_didx = -1, rx_didx = -1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tsmon_top u_tsmon_top (
    .clk(clk), .rst(rst),
    .tx_sel(tx_sel), .tx_e1(tx_e1), .tx_bit_stb(tx_bit_stb),
    .tx_data(tx_data), .tx_frame_start(tx_frame_start),
    .tx_mon_byte(tx_mon_byte), .tx_mon_done(tx_mon_done),
    .rx_sel(rx_sel), .rx_e1(rx_e1), .rx_bit_stb(rx_bit_stb),
    .rx_data(rx_data), .rx_frame_start(rx_frame_start),
    .rx_mon_byte(rx_mon_byte), .rx_mon_done(rx_mon_done)
  );

  always @(posedge clk) begin
    #1;
    if (tx_mon_done) begin tx_dcnt++; tx_didx = tx_idx; end
    if (rx_mon_done) begin rx_dcnt++; rx_didx = rx_idx; end
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return 8'(k * 29 + 5) ^ seed;
  endfunction

  function automatic logic exp_bit(input bit e1, input logic [7:0] seed, input int p);
    int q;
    logic [7:0] b;
    if (!e1) begin
      if (p == 0) return 1'b1;
      q = p - 1;
    end else q = p;
    b = pat(seed, q / 8);
    return b[7 - (q % 8)];
  endfunction

  function automatic int last_idx(input bit e1, input int sel);
    return e1 ? 8 * sel + 7 : 8 * sel + 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tx_bit_stb = 0; rx_bit_stb = 0; tx_frame_start = 0; rx_frame_start = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tx_dcnt = 0; rx_dcnt = 0; tx_didx = -1; rx_didx = -1;
  endtask

  task automatic send_frame(input bit te1, input logic [4:0] tsel, input logic [7:0] tseed,
                            input bit re1, input logic [4:0] rsel, input logic [7:0] rseed,
                            input int gap, input int chg_at, input logic [4:0] tsel2,
                            input logic [4:0] rsel2, input bit with_fs);
    int tlen, rlen;
    tlen = te1 ? 256 : 193;
    rlen = re1 ? 256 : 193;
    @(negedge clk);
    tx_e1 = te1; rx_e1 = re1; tx_sel = tsel; rx_sel = rsel;
    for (int i = 0; i < 256; i++) begin
      if (i != 0) @(negedge clk);
      if (i == chg_at) begin tx_sel = tsel2; rx_sel = rsel2; end
      tx_idx = i; rx_idx = i;
      tx_bit_stb = (i < tlen);
      rx_bit_stb = (i < rlen);
      tx_data = (i < tlen) ? exp_bit(te1, tseed, i) : 1'b0;
      rx_data = (i < rlen) ? exp_bit(re1, rseed, i) : 1'b0;
      tx_frame_start = with_fs && (i == 0);
      rx_frame_start = with_fs && (i == 0);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        tx_bit_stb = 0; rx_bit_stb = 0; tx_frame_start = 0; rx_frame_start = 0;
        tx_data = ~tx_data; rx_data = ~rx_data;
      end
    end
    @(negedge clk);
    tx_bit_stb = 0; rx_bit_stb = 0; tx_frame_start = 0; rx_frame_start = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_path(input string req, input int cnt, input int exp_cnt,
                             input logic [7:0] b, input logic [7:0] exp_b,
                             input int idx, input int exp_idx);
    check(cnt == exp_cnt, {req, " done count"}, cnt, exp_cnt);
    check(b == exp_b, {req, " byte"}, int'(b), int'(exp_b));
    if (exp_idx >= 0) check(idx == exp_idx, {req, " done timing bit"}, idx, exp_idx);
  endtask

  // R1 reset values, R9 no capture before frame start
  task automatic t_reset_and_prestart();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(tx_mon_byte == 8'h00 && rx_mon_byte == 8'h00, "R1 bytes in reset",
          int'(tx_mon_byte), 0);
    check(!tx_mon_done && !rx_mon_done, "R1 done in reset", int'(tx_mon_done), 0);
    do_reset();
    @(posedge clk); #1;
    check(tx_mon_byte == 8'h00 && !tx_mon_done, "R1 after reset", int'(tx_mon_byte), 0);
    send_frame(1, 5'd0, 8'h3C, 1, 5'd2, 8'hC3, 0, -1, 5'd0, 5'd2, 0);
    check(tx_dcnt == 0 && rx_dcnt == 0, "R9 no capture before frame start", tx_dcnt + rx_dcnt, 0);
    check(tx_mon_byte == 8'h00, "R9 byte untouched", int'(tx_mon_byte), 0);
  endtask

  // R2 E1 capture, R8 concurrent paths, R5 one done per frame
  task automatic t_e1_basic();
    int c0t, c0r;
    c0t = tx_dcnt; c0r = rx_dcnt;
    send_frame(1, 5'd5, 8'h11, 1, 5'd14, 8'h96, 0, -1, 5'd5, 5'd14, 1);
    expect_path("R2 tx E1 ch6", tx_dcnt - c0t, 1, tx_mon_byte, pat(8'h11, 5), tx_didx, last_idx(1, 5));
    expect_path("R8 rx E1 ch15", rx_dcnt - c0r, 1, rx_mon_byte, pat(8'h96, 14), rx_didx, last_idx(1, 14));
  endtask

  // R3 T1 framing bit skipped, first and last T1 slots
  task automatic t_t1_basic();
    int c0t, c0r;
    c0t = tx_dcnt; c0r = rx_dcnt;
    send_frame(0, 5'd0, 8'hA5, 0, 5'd23, 8'h5A, 0, -1, 5'd0, 5'd23, 1);
    expect_path("R3 tx T1 slot0", tx_dcnt - c0t, 1, tx_mon_byte, pat(8'hA5, 0), tx_didx, last_idx(0, 0));
    expect_path("R3 rx T1 slot23", rx_dcnt - c0r, 1, rx_mon_byte, pat(8'h5A, 23), rx_didx, last_idx(0, 23));
  endtask

  // R10 gaps between strobes, R6 E1 slot 31, mixed modes for R8
  task automatic t_gaps();
    int c0t, c0r;
    c0t = tx_dcnt; c0r = rx_dcnt;
    send_frame(1, 5'd31, 8'h7E, 0, 5'd9, 8'h42, 2, -1, 5'd31, 5'd9, 1);
    expect_path("R10 tx E1 slot31 with gaps", tx_dcnt - c0t, 1, tx_mon_byte, pat(8'h7E, 31), tx_didx, last_idx(1, 31));
    expect_path("R10 rx T1 with gaps", rx_dcnt - c0r, 1, rx_mon_byte, pat(8'h42, 9), rx_didx, last_idx(0, 9));
  endtask

  // R6 invalid T1 select, R4 byte held
  task automatic t_t1_invalid();
    int c0t, c0r;
    logic [7:0] held;
    held = tx_mon_byte;
    c0t = tx_dcnt; c0r = rx_dcnt;
    send_frame(0, 5'd27, 8'hF0, 1, 5'd27, 8'h0F, 0, -1, 5'd27, 5'd27, 1);
    expect_path("R6 tx T1 sel27 ignored", tx_dcnt - c0t, 0, tx_mon_byte, held, 0, -1);
    check(tx_mon_byte == held, "R4 byte held without done", int'(tx_mon_byte), int'(held));
    expect_path("R6 rx E1 sel27 captured", rx_dcnt - c0r, 1, rx_mon_byte, pat(8'h0F, 27), rx_didx, last_idx(1, 27));
  endtask

  // R7 select change mid-frame waits for next frame start
  task automatic t_sel_change();
    int c0t, c0r;
    c0t = tx_dcnt; c0r = rx_dcnt;
    send_frame(1, 5'd2, 8'h99, 0, 5'd4, 8'h66, 0, 3, 5'd1, 5'd6, 1);
    expect_path("R7 tx old select kept", tx_dcnt - c0t, 1, tx_mon_byte, pat(8'h99, 2), tx_didx, last_idx(1, 2));
    expect_path("R7 rx old select kept", rx_dcnt - c0r, 1, rx_mon_byte, pat(8'h66, 4), rx_didx, last_idx(0, 4));
    c0t = tx_dcnt; c0r = rx_dcnt;
    send_frame(1, 5'd1, 8'h24, 0, 5'd6, 8'hB7, 0, -1, 5'd1, 5'd6, 1);
    expect_path("R7 tx new select used", tx_dcnt - c0t, 1, tx_mon_byte, pat(8'h24, 1), tx_didx, last_idx(1, 1));
    expect_path("R7 rx new select used", rx_dcnt - c0r, 1, rx_mon_byte, pat(8'hB7, 6), rx_didx, last_idx(0, 6));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_and_prestart();
    t_e1_basic();
    t_t1_basic();
    t_gaps();
    t_t1_invalid();
    t_sel_change();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule